// File: doc/BRIEF.md
# Tick-Committed Real-Time Clock

This block is a calendar-free real-time clock that sits on a small register bus in a slow, always-on clock domain. A divider turns the raw clock into one-second ticks. A packed counter advances by one second on each tick and carries seconds into minutes, minutes into hours, and hours into a running day count. An alarm register is compared against the counter. A status register records second, minute, hour and day events and alarm matches. A control register selects which status bits drive the single interrupt line.

Writes to the time, alarm, control and prescaler registers are not applied when they arrive. Each one is held and committed at the next tick. Only one write can be held at a time, and any further write that arrives while one is held is dropped. Software must therefore poll the pending flag, or wait for the completion flag, before issuing the next write. The status register is the exception: writing ones to it clears the matching bits in the same cycle.

Top module: `rtc_sec_sync`

## Requirements
- R1: The time register packs seconds in bits 5:0, minutes in bits 11:6, hours in bits 16:12 and days in bits 31:17. Each tick adds one second; seconds and minutes wrap at 60 and hours at 24, each carrying into the next field, and the day field wraps from 32767 to 0.
- R2: A write to address 0 (time), 1 (alarm), 2 (control, bits 15:0) or 4 (prescaler enable, bit 0) is held and applied at the next tick. Reads of 1, 2 and 4 return the last applied value. A read of 0 returns the live counter. If a time write is applied on a tick, the counter loads the written value on that tick instead of advancing.
- R3: A held-register write that arrives while an earlier write is still held is discarded, and the register keeps the earlier value once it is applied.
- R4: Status bit 14 reads 1 exactly while a write is held. Status bit 15 is set on the tick that applies a held write.
- R5: A write to address 3 (status) clears, in the same cycle, every status bit written as 1. It never creates a held write. An event that is set on the same edge takes precedence over the clear.
- R6: On every tick, status bit 2 is set. Bit 3 is set when the seconds wrap to zero, bit 4 when the minutes wrap, and bit 5 when the hours wrap. These bits are set whatever the control register holds. Bit 0 is reserved and stays 0.
- R7: On a tick, status bit 1 is set when the new counter value matches the alarm register in bits 16:0. Bit 6 is set when all 32 bits match.
- R8: `irq` is high exactly when some status bit, bit 14 included, is 1 and its control bit is also 1.
- R9: With the prescaler enable at 1, a tick occurs once every DIV clocks. With it at 0, a tick occurs on every clock, for both counting and write commits.
- R10: After reset, all registers read 0, no write is held, the prescaler enable is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Raw slow clock (32.768 kHz when DIV is 32768) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr | input | 1 | Write strobe for one cycle |
| addr | input | 3 | Register address: 0 time, 1 alarm, 2 control, 3 status, 4 prescaler |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Interrupt, the OR of the enabled status bits |

## Verification
The assertions assume that `rst_n` is synchronous and that `wr` is a clean one-cycle strobe sampled at the rising edge. They also assume that a status clear is judged only on edges without a tick, because an event on that edge may set the bit again. The stimulus writes only time values whose fields are within range (seconds and minutes below 60, hours below 24). This keeps the wrap events well defined. The stimulus also spaces its directed clears so that they land between ticks. Random traffic is allowed to hit the held-write window on purpose, so that writes are dropped. A cycle-level model in the bench predicts each of those drops.

// File: rtl/rtc_sec_sync.sv
module rtc_sec_sync #(
  parameter int DIV = 32768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [2:0]  addr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        irq
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] DMAX = DW'(DIV - 1);

  logic [31:0] time_q, alarm_q, pdata_q;
  logic [15:0] ctl_q, stat_q;
  logic [DW-1:0] div_q;
  logic [2:0] psel_q;
  logic pren_q, pend_q;

  wire tick = pren_q ? (div_q == DMAX) : 1'b1;
  wire commit = pend_q & tick;
  wire c_time = commit && psel_q == 3'd0;
  wire c_alm  = commit && psel_q == 3'd1;
  wire c_ctl  = commit && psel_q == 3'd2;
  wire c_pre  = commit && psel_q == 3'd4;
  wire held_addr = addr == 3'd0 || addr == 3'd1 || addr == 3'd2 || addr == 3'd4;
  wire accept = wr && held_addr && !pend_q;

  wire [5:0]  sec = time_q[5:0];
  wire [5:0]  mnt = time_q[11:6];
  wire [4:0]  hr  = time_q[16:12];
  wire [14:0] day = time_q[31:17];
  wire s_wrap = sec >= 6'd59;
  wire m_wrap = s_wrap && mnt >= 6'd59;
  wire h_wrap = m_wrap && hr >= 5'd23;

  logic [31:0] inc;
  assign inc = {h_wrap ? day + 15'd1 : day,
                m_wrap ? (h_wrap ? 5'd0 : hr + 5'd1) : hr,
                s_wrap ? (m_wrap ? 6'd0 : mnt + 6'd1) : mnt,
                s_wrap ? 6'd0 : sec + 6'd1};

  wire [31:0] nxt_time = c_time ? pdata_q : inc;

  logic [15:0] ev;
  always_comb begin
    ev = '0;
    if (tick) begin
      ev[1]  = nxt_time[16:0] == alarm_q[16:0];
      ev[2]  = 1'b1;
      ev[3]  = s_wrap && !c_time;
      ev[4]  = m_wrap && !c_time;
      ev[5]  = h_wrap && !c_time;
      ev[6]  = nxt_time == alarm_q;
      ev[15] = commit;
    end
  end

  wire [15:0] clr = (wr && addr == 3'd3) ? wdata[15:0] : 16'h0;
  wire [15:0] stat_view = stat_q | {1'b0, pend_q, 14'h0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      time_q <= '0; alarm_q <= '0; ctl_q <= '0; stat_q <= '0;
      pdata_q <= '0; psel_q <= '0; pend_q <= 1'b0; pren_q <= 1'b0; div_q <= '0;
    end else begin
      div_q <= (!pren_q || tick) ? '0 : div_q + 1'b1;
      if (tick) time_q <= nxt_time;
      if (c_alm) alarm_q <= pdata_q;
      if (c_ctl) ctl_q <= pdata_q[15:0];
      if (c_pre) pren_q <= pdata_q[0];
      stat_q <= ((stat_q & ~clr) | ev) & 16'hBFFF;
      if (accept) begin
        pend_q <= 1'b1;
        psel_q <= addr;
        pdata_q <= wdata;
      end else if (tick) begin
        pend_q <= 1'b0;
      end
    end
  end

  always_comb begin
    case (addr)
      3'd0: rdata = time_q;
      3'd1: rdata = alarm_q;
      3'd2: rdata = {16'h0, ctl_q};
      3'd3: rdata = {16'h0, stat_view};
      3'd4: rdata = {31'h0, pren_q};
      default: rdata = '0;
    endcase
  end

  assign irq = |(stat_view & ctl_q);

  a_r1_time_only_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(time_q));
  a_r3_held_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && !tick |=> $stable(pdata_q) && $stable(psel_q));
  a_r2_pend_drains: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q && tick |=> !pend_q);
  a_r4_done_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q[15]) |-> $past(pend_q));
  a_r5_clear_now: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd3 && wdata[3] && !tick |=> !stat_q[3]);
  a_r6_sw_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_q[0]);
  a_r5_clear_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr && addr == 3'd3 && !pend_q |=> !pend_q);
endmodule

// File: tb/sim_rtc_sec_sync.sv
module sim_rtc_sec_sync;
  localparam int DIV = 8;
  logic clk = 0, rst_n = 0, wr = 0;
  logic [2:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic irq;
  int errors = 0, checks = 0;
  bit done = 0;

  rtc_sec_sync #(.DIV(DIV)) u0 (.clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  logic [31:0] m_time, m_alarm, m_pd;
  logic [15:0] m_ctl, m_stat;
  logic [2:0] m_psel;
  logic m_pv, m_pren;
  int m_div;

  function automatic logic [31:0] mk(int d, int h, int m, int s);
    return {d[14:0], h[4:0], m[5:0], s[5:0]};
  endfunction

  function automatic logic [31:0] f_inc(logic [31:0] t);
    int s = t[5:0], m = t[11:6], h = t[16:12], d = t[31:17];
    s++;
    if (s == 60) begin s = 0; m++; end
    if (m == 60) begin m = 0; h++; end
    if (h == 24) begin h = 0; d = (d + 1) % 32768; end
    return mk(d, h, m, s);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    m_time = 0; m_alarm = 0; m_pd = 0; m_ctl = 0; m_stat = 0;
    m_psel = 0; m_pv = 0; m_pren = 0; m_div = 0;
  endtask

  task automatic cyc(logic w, logic [2:0] a, logic [31:0] d);
    logic tk, cm, ct, acc;
    logic [31:0] nt;
    logic [15:0] ev, clr;
    tk = m_pren ? (m_div == DIV - 1) : 1'b1;
    cm = m_pv && tk;
    ct = cm && m_psel == 3'd0;
    nt = ct ? m_pd : f_inc(m_time);
    ev = 0;
    if (tk) begin
      ev[2] = 1;
      if (!ct) begin
        ev[3] = m_time[5:0] == 59;
        ev[4] = ev[3] && m_time[11:6] == 59;
        ev[5] = ev[4] && m_time[16:12] == 23;
      end
      ev[1] = nt[16:0] == m_alarm[16:0];
      ev[6] = nt == m_alarm;
      ev[15] = cm;
    end
    clr = (w && a == 3'd3) ? d[15:0] : 16'h0;
    acc = w && (a == 0 || a == 1 || a == 2 || a == 4) && !m_pv;
    wr = w; addr = a; wdata = d;
    @(posedge clk);
    #1;
    m_div = (!m_pren || tk) ? 0 : m_div + 1;
    if (tk) m_time = nt;
    if (cm && m_psel == 1) m_alarm = m_pd;
    if (cm && m_psel == 2) m_ctl = m_pd[15:0];
    if (cm && m_psel == 4) m_pren = m_pd[0];
    m_stat = ((m_stat & ~clr) | ev) & 16'hBFFF;
    if (acc) begin m_pv = 1; m_psel = a; m_pd = d; end
    else if (tk) m_pv = 0;
    wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    logic [15:0] sv;
    sv = m_stat | {1'b0, m_pv, 14'h0};
    rd(0, v); chk("R1 time", v, m_time);
    rd(1, v); chk("R2 alarm", v, m_alarm);
    rd(2, v); chk("R2 control", v, {16'h0, m_ctl});
    rd(3, v); chk("R6 status", v, {16'h0, sv});
    rd(4, v); chk("R9 prescaler", v, {31'h0, m_pren});
    chk("R8 irq", {31'h0, irq}, {31'h0, |(sv & m_ctl)});
  endtask

  task automatic settle();
    for (int i = 0; i < 4 * DIV && m_pv; i++) cyc(0, 0, 0);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, alm;
    void'($urandom(32'd1357));
    m_reset();
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    check_all();
    chk("R10 irq low", {31'h0, irq}, 0);
    rd(4, v); chk("R10 prescaler off", v, 0);

    cyc(0, 0, 0); cyc(0, 0, 0);
    rd(0, v); chk("R9 raw rate counting", v, 32'd2);

    cyc(1, 4, 1);
    rd(3, v); chk("R4 pending bit", v[14], 1);
    rd(4, v); chk("R2 prescaler still old", v, 0);
    cyc(0, 0, 0);
    rd(3, v); chk("R4 complete bit", {v[15], v[14]}, 2'b10);
    rd(4, v); chk("R2 prescaler applied", v, 1);
    check_all();

    cyc(1, 1, 32'h0000_1111);
    cyc(1, 1, 32'h0000_2222);
    settle(); cyc(0, 0, 0);
    rd(1, v); chk("R3 second write dropped", v, 32'h0000_1111);

    while (m_div != 0) cyc(0, 0, 0);
    cyc(1, 3, 32'h0000_FFFF);
    rd(3, v); chk("R5 immediate clear", v, 0);
    check_all();

    cyc(1, 0, mk(5, 23, 59, 59)); settle();
    while (m_div != 0) cyc(0, 0, 0);
    cyc(1, 3, 32'hFFFF);
    while (m_div != 0 || m_time[5:0] != 0) cyc(0, 0, 0);
    rd(0, v); chk("R1 day carry", v, mk(6, 0, 0, 0));
    rd(3, v); chk("R6 wrap events", v[5:2], 4'hF);
    chk("R8 irq gated off", {31'h0, irq}, 0);

    cyc(1, 0, mk(32767, 23, 59, 58)); settle();
    while (m_time != mk(0, 0, 0, 0)) cyc(0, 0, 0);
    rd(0, v); chk("R1 day field wraps", v, 0);

    cyc(1, 0, mk(2, 10, 20, 30)); settle();
    alm = mk(3, 10, 20, 50);
    cyc(1, 1, alm); settle();
    cyc(1, 2, 32'h0002); settle();
    cyc(1, 3, 32'hFFFF);
    while (m_time[16:0] != alm[16:0]) cyc(0, 0, 0);
    rd(3, v); chk("R7 time-of-day match", {v[6], v[1]}, 2'b01);
    chk("R8 irq on enabled bit", {31'h0, irq}, 1);
    check_all();
    cyc(1, 0, mk(3, 10, 20, 45)); settle();
    while (m_time != alm) cyc(0, 0, 0);
    rd(3, v); chk("R7 full match", {v[6], v[1]}, 2'b11);

    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 6) cyc(0, 0, 0);
      else if (op == 6) cyc(1, 0, mk($urandom_range(0, 32767), $urandom_range(0, 23),
                                      $urandom_range(0, 59), $urandom_range(0, 59)));
      else if (op == 7) cyc(1, 1, f_inc(f_inc(m_time)) + $urandom_range(0, 3));
      else if (op == 8) cyc(1, 3, $urandom());
      else cyc(1, ($urandom_range(0, 1) == 0) ? 3'd2 : 3'd4,
               ($urandom_range(0, 3) == 0) ? 32'h0 : $urandom() | 32'h1);
      if (i % 5 == 0) check_all();
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule